// File: doc/BRIEF.md
# Flash Write-Status Read Generator

This block produces what a parallel NOR flash shows on its read path while an internal byte program or erase is running. A command decoder upstream launches an operation with a single-cycle start, an operation kind and the byte being programmed. While the operation runs, every read strobe returns a polling status byte instead of array contents. Bit 7 shows the inverted top bit of the programmed byte, or 0 for an erase. Bit 6 flips on every read, and the first read of each operation sees 1.

A per-kind cycle counter ends the busy period. A one-cycle completion pulse marks the first idle cycle. After that, reads again return whatever the external array supplies for the requested address. The array, the analog timing and the tri-state bus are all outside the block. The block only forwards the read address to the array and picks between array data and status. Operation lengths are parameters, so a simulation can use short values.

Top module: `flash_poll_status`

## Requirements
- R1: After reset, busy, done and rd_valid are 0 and rd_data is all zeros.
- R2: An op_start that arrives while idle, with op_kind 00 (byte program), 01 (sector erase) or 10 (chip erase), raises busy at the next clock edge. Busy then stays high for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles respectively.
- R3: done is high for exactly one cycle, and that cycle is the first one in which busy is low again.
- R4: A read issued while a byte program is busy returns, in bit 7, the complement of bit 7 of the programmed byte.
- R5: A read issued while a sector or chip erase is busy returns 0 in bit 7.
- R6: Bit 6 of a busy read is 1 on the first read of an operation and inverts on each later busy read. Cycles without a read do not change it.
- R7: The bit 6 sequence restarts at 1 for every new operation, whatever value it held when the previous operation ended.
- R8: In a busy read, every bit other than bits 7 and 6 is 0.
- R9: arr_addr always equals rd_addr. A read issued while idle returns arr_rdata as it was in the cycle the read was issued.
- R10: op_start while busy is discarded. It does not extend the busy period, and it does not change the operation kind or the byte that the status reports.
- R11: op_start with op_kind 11 is discarded. Busy stays low and the next read returns array data.
- R12: rd_valid and rd_data update at the clock edge after the cycle in which rd_en is high. rd_valid is 0 after any cycle without rd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | One-cycle launch of an internal operation |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| op_byte | input | DATA_W | Byte being programmed |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| arr_addr | output | ADDR_W | Address forwarded to the array |
| arr_rdata | input | DATA_W | Array data for arr_addr |
| rd_data | output | DATA_W | Read result: status while busy, array data otherwise |
| rd_valid | output | 1 | rd_data carries a new read result |
| busy | output | 1 | Internal operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |

## Verification
The bench runs operations back to back, so the toggle bit is left at 0 by one operation and must read 1 on the first read of the next. A design that forgot to re-arm it would start the new sequence at 0. A second start is injected in the middle of a program, with a different kind and byte. A design that accepted it would stretch the busy window, or flip bit 7 on the later reads. Idle cycles are placed between busy reads to catch a toggle that advances on every clock rather than on every read. The bench also checks the exact cycles where busy ends and done fires: a counter that is off by one moves the done pulse and turns the first post-operation read into a status byte. Finally, a reserved kind code is issued, which a sloppy decoder would treat as an erase.

// File: rtl/fps_pkg.sv
package fps_pkg;
   typedef enum logic [1:0] {
      OPK_PROG  = 2'b00,
      OPK_SECT  = 2'b01,
      OPK_CHIP  = 2'b10,
      OPK_RSVD  = 2'b11
   } opk_e;

   localparam int POLL_BIT   = 7;
   localparam int TOGGLE_BIT = 6;
endpackage

// File: rtl/fps_timer.sv
module fps_timer
   import fps_pkg::*;
#(
   parameter int PROG_CYC = 6,
   parameter int SECT_CYC = 9,
   parameter int CHIP_CYC = 13,
   parameter int CNT_W    = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic [1:0] kind,
   output logic       busy,
   output logic       done
);
   logic [CNT_W-1:0] remain_q;
   logic [CNT_W-1:0] dur_sel;

   always_comb begin
      case (kind)
         OPK_PROG: dur_sel = CNT_W'(PROG_CYC);
         OPK_SECT: dur_sel = CNT_W'(SECT_CYC);
         default:  dur_sel = CNT_W'(CHIP_CYC);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         remain_q <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy     <= 1'b1;
            remain_q <= dur_sel - CNT_W'(1);
         end else if (busy) begin
            if (remain_q == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               remain_q <= remain_q - CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/fps_op_hold.sv
module fps_op_hold
   import fps_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [1:0]        kind,
   input  logic [DATA_W-1:0] byte_in,
   output logic              is_prog,
   output logic              prog_msb
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_prog  <= 1'b0;
         prog_msb <= 1'b0;
      end else if (accept) begin
         is_prog  <= (kind == OPK_PROG);
         prog_msb <= byte_in[POLL_BIT];
      end
   end
endmodule

// File: rtl/fps_read_mux.sv
module fps_read_mux
   import fps_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              busy,
   input  logic              is_prog,
   input  logic              prog_msb,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   logic              tog_q;
   logic [DATA_W-1:0] status_w;
   logic [DATA_W-1:0] pick_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tog_q <= 1'b1;
      else if (accept)
         tog_q <= 1'b1;
      else if (rd_en && busy)
         tog_q <= ~tog_q;
   end

   always_comb begin
      status_w             = '0;
      status_w[POLL_BIT]   = is_prog ? ~prog_msb : 1'b0;
      status_w[TOGGLE_BIT] = tog_q;
   end

   assign pick_w = busy ? status_w : arr_rdata;

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
         end else begin
            rd_valid <= rd_en;
            if (rd_en)
               rd_data <= pick_w;
         end
      end
   end else begin : g_comb_out
      assign rd_data  = rd_en ? pick_w : '0;
      assign rd_valid = rd_en;
   end
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
   import fps_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 16,
   parameter int PROG_CYC = 6,
   parameter int SECT_CYC = 9,
   parameter int CHIP_CYC = 13,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic [1:0]        op_kind,
   input  logic [DATA_W-1:0] op_byte,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] arr_addr,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              busy,
   output logic              done
);
   localparam int MAX_PE  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
   localparam int MAX_CYC = (MAX_PE > CHIP_CYC) ? MAX_PE : CHIP_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must hold the polling and toggle bits");
   end
   if (PROG_CYC < 1 || SECT_CYC < 1 || CHIP_CYC < 1) begin : g_bad_len
      $error("operation lengths must be at least one cycle");
   end

   logic accept;
   logic is_prog;
   logic prog_msb;

   assign accept   = op_start && !busy && (op_kind != OPK_RSVD);
   assign arr_addr = rd_addr;

   fps_timer #(
      .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
      .CHIP_CYC(CHIP_CYC), .CNT_W(CNT_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .accept(accept), .kind(op_kind),
      .busy(busy), .done(done)
   );

   fps_op_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .accept(accept), .kind(op_kind),
      .byte_in(op_byte), .is_prog(is_prog), .prog_msb(prog_msb)
   );

   fps_read_mux #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_mux (
      .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy),
      .is_prog(is_prog), .prog_msb(prog_msb), .rd_en(rd_en),
      .arr_rdata(arr_rdata), .rd_data(rd_data), .rd_valid(rd_valid)
   );
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_start,
   input logic [1:0]        op_kind,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid,
   input logic              busy,
   input logic              done
);
   localparam logic [DATA_W-1:0] QUIET_MASK = ~(DATA_W'(8'hC0));

   a_r3_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && !busy && op_kind != 2'b11) |=> busy);

   a_r11_rsvd_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && !busy && op_kind == 2'b11) |=> !busy);

   if (OUT_REG) begin : g_reg_chk
      a_r12_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
         rd_en |=> rd_valid);

      a_r12_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en |=> !rd_valid);

      a_r8_status_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && busy) |=> ((rd_data & QUIET_MASK) == '0));
   end
endmodule

bind flash_poll_status fps_checker #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_fps_chk (
   .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
   .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
   .busy(busy), .done(done)
);

// File: tb/tb_flash_poll_status.sv
module tb_flash_poll_status;
   localparam int PROG_N = 6;
   localparam int SECT_N = 9;
   localparam int CHIP_N = 13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_start = 1'b0;
   logic [1:0]  op_kind = 2'b00;
   logic [7:0]  op_byte = 8'h00;
   logic        rd_en = 1'b0;
   logic [15:0] rd_addr = 16'h0000;
   logic [15:0] arr_addr;
   logic [7:0]  arr_rdata;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic        busy;
   logic        done;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   assign arr_rdata = arr_addr[7:0] ^ 8'h5A;

   flash_poll_status #(
      .DATA_W(8), .ADDR_W(16), .PROG_CYC(PROG_N),
      .SECT_CYC(SECT_N), .CHIP_CYC(CHIP_N), .OUT_REG(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
      .op_byte(op_byte), .rd_en(rd_en), .rd_addr(rd_addr),
      .arr_addr(arr_addr), .arr_rdata(arr_rdata), .rd_data(rd_data),
      .rd_valid(rd_valid), .busy(busy), .done(done)
   );

   // kind[10:9], byte[8:1], inject second start[0]
   localparam logic [10:0] VEC [4] = '{
      {2'b00, 8'h3C, 1'b1},
      {2'b00, 8'hA5, 1'b0},
      {2'b01, 8'h00, 1'b1},
      {2'b10, 8'hFF, 1'b0}
   };

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic st, input logic [1:0] k, input logic [7:0] b,
                      input logic rd, input logic [15:0] a);
      @(negedge clk);
      op_start = st; op_kind = k; op_byte = b; rd_en = rd; rd_addr = a;
      @(posedge clk);
      #1;
   endtask

   function automatic int dur_of(input logic [1:0] k);
      case (k)
         2'b00:   return PROG_N;
         2'b01:   return SECT_N;
         default: return CHIP_N;
      endcase
   endfunction

   initial begin
      #(200000 * 4);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(done == 1'b0, "R1 done", done, 0);
      chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
      chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9 idle read returns array data, address forwarded
      cyc(1'b0, 2'b00, 8'h00, 1'b1, 16'h00C3);
      chk(arr_addr == 16'h00C3, "R9 arr_addr", arr_addr, 16'h00C3);
      chk(rd_data == (8'hC3 ^ 8'h5A), "R9 idle read", rd_data, 8'hC3 ^ 8'h5A);
      chk(rd_valid == 1'b1, "R12 valid after read", rd_valid, 1);
      cyc(1'b0, 2'b00, 8'h00, 1'b0, 16'h0000);
      chk(rd_valid == 1'b0, "R12 valid drops", rd_valid, 0);

      foreach (VEC[v]) begin
         logic [1:0] k;
         logic [7:0] b;
         logic       poke;
         int         n;
         int         nread;
         logic       exp7;
         k = VEC[v][10:9];
         b = VEC[v][8:1];
         poke = VEC[v][0];
         n = dur_of(k);
         exp7 = (k == 2'b00) ? ~b[7] : 1'b0;
         nread = 0;
         cyc(1'b1, k, b, 1'b0, 16'h0000);
         chk(busy == 1'b1, "R2 busy rises", busy, 1);
         for (int i = 1; i <= n + 1; i++) begin
            logic       rd;
            logic       st;
            logic [15:0] a;
            rd = (i == 1) || (i == 3) || (i == 4) || (i == n + 1);
            st = poke && (i == 2);
            a = 16'h1200 + 16'(i * 7 + v);
            cyc(st, 2'b10, ~b, rd, a);
            chk(busy == (i < n), "R2 R10 busy window", busy, (i < n));
            chk(done == (i == n), "R3 done pulse", done, (i == n));
            chk(rd_valid == rd, "R12 rd_valid", rd_valid, rd);
            if (rd && (i - 1 < n)) begin
               logic [7:0] e;
               e = {exp7, ((nread % 2) == 0) ? 1'b1 : 1'b0, 6'b000000};
               nread++;
               if (k == 2'b00)
                  chk(rd_data[7] == e[7], "R4 R10 prog bit7", rd_data, e);
               else
                  chk(rd_data[7] == 1'b0, "R5 erase bit7", rd_data, e);
               if (nread == 1)
                  chk(rd_data[6] == 1'b1, "R7 R6 first toggle", rd_data, e);
               else
                  chk(rd_data[6] == e[6], "R6 toggle step", rd_data, e);
               chk(rd_data[5:0] == 6'd0, "R8 quiet bits", rd_data, e);
            end else if (rd) begin
               chk(rd_data == (a[7:0] ^ 8'h5A), "R9 read after done", rd_data, a[7:0] ^ 8'h5A);
            end
         end
      end

      // R11 reserved kind ignored
      cyc(1'b1, 2'b11, 8'h12, 1'b0, 16'h0000);
      chk(busy == 1'b0, "R11 rsvd busy", busy, 0);
      cyc(1'b0, 2'b00, 8'h00, 1'b1, 16'h0044);
      chk(rd_data == (8'h44 ^ 8'h5A), "R11 rsvd read", rd_data, 8'h44 ^ 8'h5A);
      chk(busy == 1'b0, "R11 still idle", busy, 0);

      // start and read in same idle cycle: read sees the array
      cyc(1'b1, 2'b01, 8'h00, 1'b1, 16'h0077);
      chk(rd_data == (8'h77 ^ 8'h5A), "R9 read with start", rd_data, 8'h77 ^ 8'h5A);
      chk(busy == 1'b1, "R2 sector start", busy, 1);
      cyc(1'b0, 2'b00, 8'h00, 1'b1, 16'h0077);
      chk(rd_data == 8'h40, "R5 R6 erase status", rd_data, 8'h40);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule